// File: doc/BRIEF.md
# Timer clock source selector

This block is the clock front end of a group of three 16-bit timer channels. For each channel it picks one counting source, optionally counts on the falling edge instead of the rising edge, optionally qualifies counting with a second external line, and issues a single-cycle count-enable pulse to that channel's counter. It does not produce a derived clock. Every path runs in the system clock domain.

Three external clock lines are built at group level. Each line can take a device pin, be held low, or follow the A output of one of the other two channels, so channels can be chained. Internal prescaler clocks arrive as divided level signals that are already synchronous to the system clock. Device pins are asynchronous and pass through a two-flop synchronizer. Each channel has its own enable and disable commands and a status bit. A group sync command clears all three counters in the same cycle.

Top module: `tmr_clk_front`

## Requirements
- R1: Source codes 0 to 4 on a channel's 3-bit source field select internal tick inputs 0 to 4. A rising level on the selected tick gives exactly one count-enable pulse, high in the cycle after the clock edge that samples the new level.
- R2: Source codes 5, 6 and 7 select external lines 0, 1 and 2.
- R3: External line 0 uses a 2-bit code. Code 0 is pin 0, code 1 holds the line low, code 2 is channel 1's A output, and code 3 is channel 2's A output.
- R4: External line 1 takes pin 1, low, channel 0's A output or channel 2's A output for codes 0 to 3. External line 2 takes pin 2, low, channel 0's A output or channel 1's A output for codes 0 to 3.
- R5: With the channel's invert bit at 1, the pulse follows a falling edge of the selected source, and a rising edge gives no pulse.
- R6: A 2-bit gate code of 0 never blocks counting. Gate codes 1, 2 and 3 pass a source edge only while external line 0, 1 or 2 is high in the same cycle as the edge.
- R7: A command write with bit 0 set turns the channel's clock on, and one with bit 1 set turns it off. The status output shows the new state one cycle after the write. When both bits are set, off wins. Without a write, the status holds.
- R8: A channel whose clock is off issues no count-enable pulse.
- R9: A one-cycle sync command makes all three counter-clear outputs high together for exactly one cycle, in the cycle after the command.
- R10: An edge on a device pin reaches the count-enable output three clock edges after the pin changes (two synchronizer stages plus the pulse register). An edge on a channel A output reaches it after one clock edge.
- R11: After reset, all count-enable, counter-clear and status outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 5 | Internal prescaler clock levels, synchronous |
| pin_clk_i | input | 3 | Device clock pins, asynchronous |
| chan_a_i | input | 3 | A output of each channel, synchronous |
| ext_sel_i | input | 6 | 2-bit source code per external line, line n at bits 2n+1:2n |
| src_sel_i | input | 9 | 3-bit source code per channel, channel n at bits 3n+2:3n |
| inv_i | input | 3 | Count on falling edge, per channel |
| gate_i | input | 6 | 2-bit gate code per channel, channel n at bits 2n+1:2n |
| cmd_wr_i | input | 3 | Command write strobe per channel |
| cmd_i | input | 2 | Command data: bit 0 enable, bit 1 disable |
| sync_i | input | 1 | Group sync command |
| cnt_en_o | output | 3 | Count-enable pulse per channel |
| cnt_clr_o | output | 3 | Counter-clear pulse per channel |
| clk_on_o | output | 3 | Channel clock enabled status |

## Verification
An internal tick or a chained A output shows up on the count-enable output after one clock edge. A device pin takes three edges. A command shows on the status one edge after the write, and a sync command shows on the clear outputs one edge after it is applied. The bench drives every stimulus on a falling clock edge and then reads the target output on each of the following falling edges, up to one past the expected latency. It expects high only at the stated latency and low at every other sample, so both an early pulse and a late or stretched one fail.

// File: rtl/tcs_pkg.sv
// Shared constants and helpers for the timer clock front end.
// Assumes a fixed group of three channels: the 2-bit line codes only
// have room for two chaining partners per line.
package tcs_pkg;
    localparam int NUM_CH     = 3;
    localparam int EXT_SEL_W  = 2;
    localparam int GATE_W     = 2;

    typedef enum logic [EXT_SEL_W-1:0] {
        EXT_PIN   = 2'd0,
        EXT_NONE  = 2'd1,
        EXT_PEER0 = 2'd2,
        EXT_PEER1 = 2'd3
    } ext_code_e;

    // Index of the k-th other channel (ascending) seen from a given line.
    function automatic int peer_of(input int line, input int k);
        return (k < line) ? k : k + 1;
    endfunction
endpackage

// File: rtl/tcs_sync_bank.sv
// Multi-stage flop synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is a slow level; no bus coherency is provided.
module tcs_sync_bank #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= din;
                end
            end else begin : g_next
                // Shift through the remaining settling stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/tcs_ext_mux.sv
// Builds the group's external clock lines from synchronized pins or
// from the other channels' A outputs. Purely combinational.
// Assumes the A outputs are registered in the system clock domain.
module tcs_ext_mux
    import tcs_pkg::*;
(
    input  logic [NUM_CH-1:0]           pin_sync,
    input  logic [NUM_CH-1:0]           chan_a,
    input  logic [NUM_CH*EXT_SEL_W-1:0] ext_sel,
    output logic [NUM_CH-1:0]           ext_lvl
);
    generate
        for (genvar ln = 0; ln < NUM_CH; ln++) begin : g_line
            localparam int P0 = peer_of(ln, 0);
            localparam int P1 = peer_of(ln, 1);
            ext_code_e code;
            assign code = ext_code_e'(ext_sel[ln*EXT_SEL_W +: EXT_SEL_W]);

            // Pick the level driving this external line.
            always_comb begin
                unique case (code)
                    EXT_PIN:   ext_lvl[ln] = pin_sync[ln];
                    EXT_NONE:  ext_lvl[ln] = 1'b0;
                    EXT_PEER0: ext_lvl[ln] = chan_a[P0];
                    EXT_PEER1: ext_lvl[ln] = chan_a[P1];
                    default:   ext_lvl[ln] = 1'b0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/tcs_chan_front.sv
// One channel's front end: source select, edge polarity, gate, on/off
// state and the registered count-enable pulse.
// Assumes every source level is already in the system clock domain.
module tcs_chan_front
    import tcs_pkg::*;
#(
    parameter int NUM_TICK = 5,
    localparam int SRC_W   = $clog2(NUM_TICK + NUM_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TICK-1:0] tick_lvl,
    input  logic [NUM_CH-1:0]   ext_lvl,
    input  logic [SRC_W-1:0]    src_sel,
    input  logic                inv,
    input  logic [GATE_W-1:0]   gate,
    input  logic                cmd_wr,
    input  logic                cmd_en,
    input  logic                cmd_dis,
    output logic                cnt_en,
    output logic                clk_on
);
    logic src_lvl, src_prev, gate_ok, evt;

    // Select the counting source level from ticks or external lines.
    always_comb begin
        src_lvl = 1'b0;
        for (int t = 0; t < NUM_TICK; t++)
            if (src_sel == SRC_W'(t)) src_lvl = tick_lvl[t];
        for (int e = 0; e < NUM_CH; e++)
            if (src_sel == SRC_W'(NUM_TICK + e)) src_lvl = ext_lvl[e];
    end

    // Decide whether the burst gate lets an edge through.
    always_comb begin
        gate_ok = 1'b1;
        for (int g = 0; g < NUM_CH; g++)
            if (gate == GATE_W'(g + 1)) gate_ok = ext_lvl[g];
    end

    // Remember the previous source level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_prev <= 1'b0;
        else        src_prev <= src_lvl;
    end

    assign evt = inv ? (src_prev & ~src_lvl) : (~src_prev & src_lvl);

    // Track the on/off state; disable takes priority over enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_on <= 1'b0;
        end else if (cmd_wr) begin
            if (cmd_dis)     clk_on <= 1'b0;
            else if (cmd_en) clk_on <= 1'b1;
        end
    end

    // Register the single-cycle count-enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_en <= 1'b0;
        else        cnt_en <= evt & gate_ok & clk_on;
    end
endmodule

// File: rtl/tmr_clk_front.sv
// Top of the timer clock front end: pin synchronizers, external line mux,
// one front end per channel and the group sync clear.
// Assumes static configuration inputs while counting is of interest.
module tmr_clk_front
    import tcs_pkg::*;
#(
    parameter int NUM_TICK    = 5,
    parameter int SYNC_STAGES = 2,
    localparam int SRC_W      = $clog2(NUM_TICK + NUM_CH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_TICK-1:0]         tick_i,
    input  logic [NUM_CH-1:0]           pin_clk_i,
    input  logic [NUM_CH-1:0]           chan_a_i,
    input  logic [NUM_CH*EXT_SEL_W-1:0] ext_sel_i,
    input  logic [NUM_CH*SRC_W-1:0]     src_sel_i,
    input  logic [NUM_CH-1:0]           inv_i,
    input  logic [NUM_CH*GATE_W-1:0]    gate_i,
    input  logic [NUM_CH-1:0]           cmd_wr_i,
    input  logic [1:0]                  cmd_i,
    input  logic                        sync_i,
    output logic [NUM_CH-1:0]           cnt_en_o,
    output logic [NUM_CH-1:0]           cnt_clr_o,
    output logic [NUM_CH-1:0]           clk_on_o
);
    logic [NUM_CH-1:0] pin_sync;
    logic [NUM_CH-1:0] ext_lvl;

    tcs_sync_bank #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_clk_i),
        .dout (pin_sync)
    );

    tcs_ext_mux u_ext_mux (
        .pin_sync(pin_sync),
        .chan_a  (chan_a_i),
        .ext_sel (ext_sel_i),
        .ext_lvl (ext_lvl)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            tcs_chan_front #(.NUM_TICK(NUM_TICK)) u_front (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick_lvl(tick_i),
                .ext_lvl (ext_lvl),
                .src_sel (src_sel_i[c*SRC_W +: SRC_W]),
                .inv     (inv_i[c]),
                .gate    (gate_i[c*GATE_W +: GATE_W]),
                .cmd_wr  (cmd_wr_i[c]),
                .cmd_en  (cmd_i[0]),
                .cmd_dis (cmd_i[1]),
                .cnt_en  (cnt_en_o[c]),
                .clk_on  (clk_on_o[c])
            );
        end
    endgenerate

    // Broadcast the sync command as one aligned clear to every counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_clr_o <= '0;
        else        cnt_clr_o <= {NUM_CH{sync_i}};
    end
endmodule

// File: rtl/tmr_clk_front_chk.sv
// Property checker for the timer clock front end, bound to the top.
// Observes ports plus the external line levels from the mux.
module tmr_clk_front_chk
    import tcs_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_CH*EXT_SEL_W-1:0] ext_sel_i,
    input logic [NUM_CH*GATE_W-1:0]    gate_i,
    input logic [NUM_CH-1:0]           cmd_wr_i,
    input logic [1:0]                  cmd_i,
    input logic                        sync_i,
    input logic [NUM_CH-1:0]           ext_lvl,
    input logic [NUM_CH-1:0]           cnt_en_o,
    input logic [NUM_CH-1:0]           cnt_clr_o,
    input logic [NUM_CH-1:0]           clk_on_o
);
    logic [NUM_CH:0] gate_tab;
    assign gate_tab = {ext_lvl, 1'b1};

    AST_CLR_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (cnt_clr_o == '1)); // R9
    AST_CLR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_o == '0) || (cnt_clr_o == '1)); // R9

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
            AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_wr_i[c] && cmd_i[1]) |=> !clk_on_o[c]); // R7
            AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_wr_i[c] && cmd_i == 2'b01) |=> clk_on_o[c]); // R7
            AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !cmd_wr_i[c] |=> $stable(clk_on_o[c])); // R7
            AST_OFF_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_en_o[c] |-> $past(clk_on_o[c])); // R8
            AST_GATE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_en_o[c] |-> $past(gate_tab[gate_i[c*GATE_W +: GATE_W]])); // R6
            AST_LINE_NONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                (ext_sel_i[c*EXT_SEL_W +: EXT_SEL_W] == 2'd1) |-> !ext_lvl[c]); // R3
        end
    endgenerate
endmodule

bind tmr_clk_front tmr_clk_front_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_sel_i(ext_sel_i),
    .gate_i   (gate_i),
    .cmd_wr_i (cmd_wr_i),
    .cmd_i    (cmd_i),
    .sync_i   (sync_i),
    .ext_lvl  (ext_lvl),
    .cnt_en_o (cnt_en_o),
    .cnt_clr_o(cnt_clr_o),
    .clk_on_o (clk_on_o)
);

// File: tb/tmr_clk_front_test.sv
// Directed bench for the timer clock front end.
module tmr_clk_front_test;
    localparam int CLK_PERIOD = 10;
    localparam int PIN_LAT    = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] tick_i = '0;
    logic [2:0] pin_clk_i = '0;
    logic [2:0] chan_a_i = '0;
    logic [5:0] ext_sel_i = 6'b010101;
    logic [8:0] src_sel_i = '0;
    logic [2:0] inv_i = '0;
    logic [5:0] gate_i = '0;
    logic [2:0] cmd_wr_i = '0;
    logic [1:0] cmd_i = '0;
    logic       sync_i = 1'b0;
    logic [2:0] cnt_en_o, cnt_clr_o, clk_on_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    tmr_clk_front uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pin_clk_i(pin_clk_i),
        .chan_a_i(chan_a_i), .ext_sel_i(ext_sel_i), .src_sel_i(src_sel_i),
        .inv_i(inv_i), .gate_i(gate_i), .cmd_wr_i(cmd_wr_i), .cmd_i(cmd_i),
        .sync_i(sync_i), .cnt_en_o(cnt_en_o), .cnt_clr_o(cnt_clr_o),
        .clk_on_o(clk_on_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sample one channel's pulse at each step up to lat+1.
    task automatic watch(input int ch, input int lat, input bit exp, input string req);
        for (int s = 1; s <= lat + 1; s++) begin
            step(1);
            check(req, cnt_en_o[ch], (exp && s == lat) ? 1 : 0);
        end
    endtask

    task automatic quiet();
        tick_i = '0; pin_clk_i = '0; chan_a_i = '0;
        step(5);
    endtask

    task automatic command(input int ch, input logic [1:0] c);
        cmd_wr_i = 3'b000; cmd_wr_i[ch] = 1'b1; cmd_i = c;
        step(1);
        cmd_wr_i = '0; cmd_i = '0;
    endtask

    task automatic t_reset();
        check("R11 cnt_en", cnt_en_o, 0);
        check("R11 cnt_clr", cnt_clr_o, 0);
        check("R11 clk_on", clk_on_o, 0);
    endtask

    task automatic t_commands();
        command(0, 2'b01); check("R7 enable", clk_on_o[0], 1);
        command(0, 2'b11); check("R7 both, off wins", clk_on_o[0], 0);
        command(0, 2'b01); step(2); check("R7 hold", clk_on_o[0], 1);
        command(0, 2'b10); check("R7 disable", clk_on_o[0], 0);
        for (int c = 0; c < 3; c++) command(c, 2'b01);
        check("R7 all on", clk_on_o, 7);
    endtask

    task automatic t_internal();
        for (int t = 0; t < 5; t++) begin
            int ch = t % 3;
            src_sel_i[ch*3 +: 3] = 3'(t);
            quiet();
            tick_i[t] = 1'b1;
            watch(ch, 1, 1, "R1 tick rise");
            tick_i[t] = 1'b0;
            watch(ch, 1, 0, "R1 tick fall ignored");
        end
    endtask

    task automatic t_disabled();
        src_sel_i[3 +: 3] = 3'd2; quiet();
        command(1, 2'b10);
        tick_i[2] = 1'b1;
        watch(1, 1, 0, "R8 off no pulse");
        command(1, 2'b01);
        quiet();
    endtask

    task automatic t_invert();
        src_sel_i[0 +: 3] = 3'd1; inv_i[0] = 1'b1; quiet();
        tick_i[1] = 1'b1;
        watch(0, 1, 0, "R5 rise ignored");
        tick_i[1] = 1'b0;
        watch(0, 1, 1, "R5 fall counts");
        inv_i[0] = 1'b0; quiet();
    endtask

    task automatic t_pin();
        ext_sel_i = 6'b000000; src_sel_i[0 +: 3] = 3'd5; quiet();
        pin_clk_i[0] = 1'b1;
        watch(0, PIN_LAT, 1, "R10 R2 pin0 line0");
        src_sel_i[6 +: 3] = 3'd7; quiet();
        pin_clk_i[2] = 1'b1;
        watch(2, PIN_LAT, 1, "R10 R2 pin2 line2");
        quiet();
    endtask

    task automatic t_chain();
        // line1 code2 = channel 0's A, channel 2 counts line 1
        ext_sel_i = 6'b010_1_01; ext_sel_i[3:2] = 2'd2;
        src_sel_i[6 +: 3] = 3'd6; quiet();
        chan_a_i[0] = 1'b1; watch(2, 1, 1, "R4 R10 line1 from ch0");
        // line1 code3 = channel 2's A, channel 0 counts line 1
        ext_sel_i[3:2] = 2'd3; src_sel_i[0 +: 3] = 3'd6; quiet();
        chan_a_i[2] = 1'b1; watch(0, 1, 1, "R4 line1 from ch2");
        // line2 code2 = ch0 A, code3 = ch1 A
        ext_sel_i[5:4] = 2'd2; src_sel_i[3 +: 3] = 3'd7; quiet();
        chan_a_i[0] = 1'b1; watch(1, 1, 1, "R4 line2 from ch0");
        ext_sel_i[5:4] = 2'd3; src_sel_i[0 +: 3] = 3'd7; quiet();
        chan_a_i[1] = 1'b1; watch(0, 1, 1, "R4 line2 from ch1");
        // line0 code2 = ch1 A, code3 = ch2 A, code1 = low
        ext_sel_i[1:0] = 2'd2; src_sel_i[3 +: 3] = 3'd5; quiet();
        chan_a_i[1] = 1'b1; watch(1, 1, 1, "R3 line0 from ch1");
        ext_sel_i[1:0] = 2'd3; quiet();
        chan_a_i[2] = 1'b1; watch(1, 1, 1, "R3 line0 from ch2");
        ext_sel_i[1:0] = 2'd1; quiet();
        chan_a_i = 3'b111; pin_clk_i[0] = 1'b1;
        watch(1, PIN_LAT, 0, "R3 line0 none");
        quiet();
    endtask

    task automatic t_gate();
        ext_sel_i = 6'b010101; ext_sel_i[3:2] = 2'd0;
        src_sel_i[0 +: 3] = 3'd3; gate_i[1:0] = 2'd2; quiet();
        tick_i[3] = 1'b1; watch(0, 1, 0, "R6 gate closed");
        tick_i[3] = 1'b0; pin_clk_i[1] = 1'b1; step(PIN_LAT + 1);
        tick_i[3] = 1'b1; watch(0, 1, 1, "R6 gate open");
        tick_i[3] = 1'b0; gate_i[1:0] = 2'd0; pin_clk_i[1] = 1'b0; step(PIN_LAT + 1);
        tick_i[3] = 1'b1; watch(0, 1, 1, "R6 no gate");
        quiet();
    endtask

    task automatic t_sync();
        sync_i = 1'b1; step(1); sync_i = 1'b0;
        check("R9 clear all", cnt_clr_o, 7);
        step(1);
        check("R9 clear one cycle", cnt_clr_o, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_commands();
        t_internal();
        t_disabled();
        t_invert();
        t_pin();
        t_chain();
        t_gate();
        t_sync();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule